// File: doc/BRIEF.md
# Streaming Hamming Code Generator for 256-Byte Blocks

This block computes a three-byte single-error-correcting code over a block of 256 data bytes that arrive one byte per clock on a valid-qualified stream. A one-cycle start pulse opens a block. The block counts the accepted bytes itself. For every byte it forms six column-parity bits and an overall parity flag. It XOR-folds the column bits into a 6-bit accumulator. Whenever a byte has odd parity, it also folds the byte's index and the index's complement into two line registers.

When the 256th byte is accepted, the block packs the result into three code bytes and pulses a done flag for one cycle. The two line registers are bit-interleaved into a high and a low line byte, and both are inverted. The column accumulator is inverted and padded with two ones. A static ordering input chooses which line byte comes first. The code stays on the outputs until the next start.

The control is a three-state machine:
- `ST_IDLE` is the state after reset.
- `ST_RUN` accepts bytes.
- `ST_DONE` holds the result.

The transitions are:
- IDLE→RUN on start.
- RUN→RUN on start, which restarts the block.
- RUN→DONE on the last byte.
- DONE→RUN on start.

Top module: `ecc_stream_gen`

## Requirements
- R1: After reset, `done_o` is 0 and all three code outputs are 0x00.
- R2: Column parity bit 2k+j of a byte is the XOR of the data bits whose position has bit k equal to j, for k in 0..2 and j in 0..1. A lone 0x01 at index 0 therefore yields code byte 2 = 0xAB, and a lone 0x02 at index 0 yields 0xA7.
- R3: For each odd-parity byte, its 8-bit index is XORed into line register A and its complement into line register B. A lone 0x80 at index 0xA5 gives `ecc0_o`=0x66 and `ecc1_o`=0x99 in normal order.
- R4: The high line byte is A[7],B[7],A[6],B[6],A[5],B[5],A[4],B[4] from bit 7 down to bit 0. The low line byte is the same pattern built from A[3:0] and B[3:0]. With `alt_order_i`=0, `ecc0_o` is the inverted high line byte and `ecc1_o` is the inverted low line byte.
- R5: With `alt_order_i`=1, `ecc0_o` and `ecc1_o` are exchanged relative to R4.
- R6: `ecc2_o` equals the inverted 6-bit column accumulator in bits 7..2, with bits 1..0 equal to 1.
- R7: A block of 256 zero bytes yields the code FF FF FF.
- R8: `done_o` rises in the cycle after the clock edge that accepts the 256th byte and lasts exactly one cycle. The code outputs hold their values until the next start.
- R9: A cycle with `valid_i` low changes no state, so gaps in the stream do not alter the code.
- R10: A start pulse during a block discards it and restarts the byte count at 0. A byte presented in the same cycle as start is not taken.
- R11: In IDLE and DONE, bytes presented without a start are ignored: no done pulse is produced and the outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that opens (or restarts) a block |
| valid_i | input | 1 | Qualifies `data_i` |
| data_i | input | 8 | Data byte |
| alt_order_i | input | 1 | Static: 1 exchanges the two line code bytes |
| done_o | output | 1 | One-cycle pulse: code is ready |
| ecc0_o | output | 8 | Code byte 0 |
| ecc1_o | output | 8 | Code byte 1 |
| ecc2_o | output | 8 | Code byte 2 (column parity) |

## Verification
The code bytes are registered at the same edge that accepts the 256th byte, and `done_o` rises together with them. Both are therefore due one cycle after that byte is driven. The bench drives inputs on falling edges and samples outputs on falling edges, so it reads `done_o` and the code at the first falling edge after the final byte's rising edge. It reads them again one edge later to confirm that the pulse has ended and the values hold. A scoreboard queue filled by the driver is drained only on a done pulse, so a missing, late or spurious pulse shows up as a mismatch or as a leftover entry.

// File: rtl/ecc_gen_pkg.sv
package ecc_gen_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } gen_state_t;
endpackage

// File: rtl/ecc_colpar.sv
module ecc_colpar #(
    parameter int DATA_W = 8,
    localparam int LOG_W = $clog2(DATA_W),
    localparam int COL_W = 2 * LOG_W
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [COL_W-1:0]  col_o,
    output logic              odd_o
);
    function automatic logic [DATA_W-1:0] pos_mask(input int k, input int j);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int p = 0; p < DATA_W; p++) begin
            if (((p >> k) & 1) == j) m[p] = 1'b1;
        end
        return m;
    endfunction

    for (genvar k = 0; k < LOG_W; k++) begin : g_grp
        assign col_o[2*k]   = ^(data_i & pos_mask(k, 0));
        assign col_o[2*k+1] = ^(data_i & pos_mask(k, 1));
    end

    assign odd_o = ^data_i;
endmodule

// File: rtl/ecc_accum.sv
module ecc_accum #(
    parameter int IDX_W = 8,
    parameter int COL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [COL_W-1:0] col_i,
    input  logic             odd_i,
    output logic [COL_W-1:0] col_nx_o,
    output logic [IDX_W-1:0] la_nx_o,
    output logic [IDX_W-1:0] lb_nx_o
);
    logic [COL_W-1:0] col_q;
    logic [IDX_W-1:0] la_q, lb_q;

    always_comb begin
        col_nx_o = col_q ^ col_i;
        la_nx_o  = odd_i ? (la_q ^ idx_i)  : la_q;
        lb_nx_o  = odd_i ? (lb_q ^ ~idx_i) : lb_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= '0;
            la_q  <= '0;
            lb_q  <= '0;
        end else if (clr_i) begin
            col_q <= '0;
            la_q  <= '0;
            lb_q  <= '0;
        end else if (en_i) begin
            col_q <= col_nx_o;
            la_q  <= la_nx_o;
            lb_q  <= lb_nx_o;
        end
    end

    // R9: an idle cycle leaves the accumulators untouched
    a_r9_accum_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !en_i) |=> ($stable(col_q) && $stable(la_q) && $stable(lb_q)));
endmodule

// File: rtl/ecc_pack.sv
module ecc_pack #(
    parameter int IDX_W = 8,
    parameter int COL_W = 6,
    localparam int HALF = IDX_W / 2
) (
    input  logic [IDX_W-1:0] la_i,
    input  logic [IDX_W-1:0] lb_i,
    input  logic [COL_W-1:0] col_i,
    input  logic             alt_i,
    output logic [IDX_W-1:0] e0_o,
    output logic [IDX_W-1:0] e1_o,
    output logic [COL_W+1:0] e2_o
);
    logic [IDX_W-1:0] hi, lo;

    for (genvar k = 0; k < HALF; k++) begin : g_mix
        assign hi[2*k+1] = la_i[HALF+k];
        assign hi[2*k]   = lb_i[HALF+k];
        assign lo[2*k+1] = la_i[k];
        assign lo[2*k]   = lb_i[k];
    end

    always_comb begin
        e0_o = alt_i ? ~lo : ~hi;
        e1_o = alt_i ? ~hi : ~lo;
        e2_o = {~col_i, 2'b11};
    end
endmodule

// File: rtl/ecc_stream_gen.sv
module ecc_stream_gen
    import ecc_gen_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int BLOCK_LEN = 256,
    localparam int IDX_W    = $clog2(BLOCK_LEN),
    localparam int COL_W    = 2 * $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              alt_order_i,
    output logic              done_o,
    output logic [IDX_W-1:0]  ecc0_o,
    output logic [IDX_W-1:0]  ecc1_o,
    output logic [COL_W+1:0]  ecc2_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLOCK_LEN - 1);

    gen_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             take, last;

    logic [COL_W-1:0] col_b, col_nx;
    logic             odd_b;
    logic [IDX_W-1:0] la_nx, lb_nx, p0, p1;
    logic [COL_W+1:0] p2;

    assign take = (state_q == ST_RUN) && valid_i && !start_i;
    assign last = (idx_q == LAST_IDX);

    ecc_colpar #(.DATA_W(DATA_W)) colpar_i (
        .data_i (data_i),
        .col_o  (col_b),
        .odd_o  (odd_b)
    );

    ecc_accum #(.IDX_W(IDX_W), .COL_W(COL_W)) accum_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (start_i),
        .en_i     (take),
        .idx_i    (idx_q),
        .col_i    (col_b),
        .odd_i    (odd_b),
        .col_nx_o (col_nx),
        .la_nx_o  (la_nx),
        .lb_nx_o  (lb_nx)
    );

    ecc_pack #(.IDX_W(IDX_W), .COL_W(COL_W)) pack_i (
        .la_i  (la_nx),
        .lb_i  (lb_nx),
        .col_i (col_nx),
        .alt_i (alt_order_i),
        .e0_o  (p0),
        .e1_o  (p1),
        .e2_o  (p2)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_RUN;
            ST_RUN: begin
                if (start_i)          state_d = ST_RUN;
                else if (take && last) state_d = ST_DONE;
            end
            ST_DONE: if (start_i) state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and byte index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start_i)   idx_q <= '0;
            else if (take) idx_q <= idx_q + 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            ecc0_o <= '0;
            ecc1_o <= '0;
            ecc2_o <= '0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                ecc0_o <= '0;
                ecc1_o <= '0;
                ecc2_o <= '0;
            end else if (take && last) begin
                done_o <= 1'b1;
                ecc0_o <= p0;
                ecc1_o <= p1;
                ecc2_o <= p2;
            end
        end
    end

    // R8: single-cycle done pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R8: result holds while waiting for the next start
    a_r8_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !start_i) |=> ($stable(ecc0_o) && $stable(ecc1_o) && $stable(ecc2_o)));
    // R6: padding bits of the column byte
    a_r6_pad_ones: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (ecc2_o[1:0] == 2'b11));
    // R9: gap cycle keeps the byte index
    a_r9_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !valid_i && !start_i) |=> $stable(idx_q));
    // R10: start restarts the count
    a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (idx_q == '0 && state_q == ST_RUN && !done_o));
    // R11: no done pulse unless a block was running
    a_r11_no_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN) |=> !done_o);
endmodule

// File: tb/ecc_stream_gen_tb_top.sv
`timescale 1ns/1ps
module ecc_stream_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       valid_i = 1'b0;
    logic [7:0] data_i = 8'h00;
    logic       alt_order_i = 1'b0;
    logic       done_o;
    logic [7:0] ecc0_o, ecc1_o, ecc2_o;

    int total = 0;
    int bad = 0;

    logic [7:0]  blk [256];
    logic [23:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    ecc_stream_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
        .data_i(data_i), .alt_order_i(alt_order_i), .done_o(done_o),
        .ecc0_o(ecc0_o), .ecc1_o(ecc1_o), .ecc2_o(ecc2_o)
    );

    task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%06h expected=%06h", req, act, exp);
        end
    endtask

    // reference model written from the requirements
    function automatic logic [23:0] ref_code(input bit alt);
        logic [5:0] col;
        logic [7:0] a, b, hi, lo;
        col = '0; a = '0; b = '0;
        for (int i = 0; i < 256; i++) begin
            logic par;
            par = 1'b0;
            for (int p = 0; p < 8; p++) begin
                if (blk[i][p]) begin
                    par = ~par;
                    for (int k = 0; k < 3; k++)
                        col[2*k + ((p >> k) & 1)] = ~col[2*k + ((p >> k) & 1)];
                end
            end
            if (par) begin
                a = a ^ 8'(i);
                b = b ^ ~8'(i);
            end
        end
        for (int k = 0; k < 4; k++) begin
            hi[2*k+1] = a[k+4]; hi[2*k] = b[k+4];
            lo[2*k+1] = a[k];   lo[2*k] = b[k];
        end
        return alt ? {~lo, ~hi, ~col, 2'b11} : {~hi, ~lo, ~col, 2'b11};
    endfunction

    // monitor: pop expected item on every done pulse
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R11 unexpected done", {ecc0_o, ecc1_o, ecc2_o}, 24'h0);
            end else begin
                logic [23:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({ecc0_o, ecc1_o, ecc2_o} == e, t, {ecc0_o, ecc1_o, ecc2_o}, e);
            end
        end
    end

    // driver: one full block, optional gaps and junk in the start cycle
    task automatic run_block(input bit alt, input int gap_every, input bit junk, input string tag);
        @(negedge clk);
        alt_order_i = alt;
        exp_q.push_back(ref_code(alt));
        tag_q.push_back(tag);
        start_i = 1'b1;
        valid_i = junk;
        data_i  = 8'h5B;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 256; i++) begin
            if (gap_every > 0 && (i % gap_every) == 0) begin
                valid_i = 1'b0;
                data_i  = 8'hFF;
                @(negedge clk);
            end
            valid_i = 1'b1;
            data_i  = blk[i];
            @(negedge clk);
        end
        valid_i = 1'b0;
        chk(done_o == 1'b1, "R8 done due one cycle after last byte", {23'h0, done_o}, 24'h1);
        @(negedge clk);
        chk(done_o == 1'b0, "R8 done lasts one cycle", {23'h0, done_o}, 24'h0);
    endtask

    task automatic clear_blk();
        for (int i = 0; i < 256; i++) blk[i] = 8'h00;
    endtask

    task automatic rand_blk();
        for (int i = 0; i < 256; i++) blk[i] = 8'($urandom);
    endtask

    initial begin
        #1ms;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [23:0] held;
        bit          stray;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk({done_o, ecc0_o, ecc1_o, ecc2_o} == 25'h0, "R1 reset state", {ecc0_o, ecc1_o, ecc2_o}, 24'h0);
        rst_n = 1'b1;

        // R11: bytes before any start are ignored
        stray = 1'b0;
        for (int i = 0; i < 40; i++) begin
            valid_i = 1'b1; data_i = 8'(i * 7 + 1);
            @(negedge clk);
            if (done_o) stray = 1'b1;
        end
        valid_i = 1'b0;
        chk(!stray && {ecc0_o, ecc1_o, ecc2_o} == 24'h0, "R11 idle bytes ignored", {ecc0_o, ecc1_o, ecc2_o}, 24'h0);

        // R7: all-zero block
        clear_blk();
        run_block(1'b0, 0, 1'b0, "R7 zero block");
        chk({ecc0_o, ecc1_o, ecc2_o} == 24'hFFFFFF, "R7 zero code", {ecc0_o, ecc1_o, ecc2_o}, 24'hFFFFFF);

        // R2, R6: single 0x01 at index 0
        clear_blk(); blk[0] = 8'h01;
        run_block(1'b0, 0, 1'b0, "R2 byte 0x01");
        chk({ecc0_o, ecc1_o, ecc2_o} == 24'hAAAAAB, "R2 R6 code for 0x01", {ecc0_o, ecc1_o, ecc2_o}, 24'hAAAAAB);

        clear_blk(); blk[0] = 8'h02;
        run_block(1'b0, 0, 1'b0, "R2 byte 0x02");
        chk(ecc2_o == 8'hA7, "R2 column byte for 0x02", {16'h0, ecc2_o}, 24'hA7);

        // R3: odd byte at index 0xA5
        clear_blk(); blk[8'hA5] = 8'h80;
        run_block(1'b0, 0, 1'b0, "R3 index fold");
        chk({ecc0_o, ecc1_o} == 16'h6699, "R3 line bytes", {8'h0, ecc0_o, ecc1_o}, 24'h006699);
        chk(ecc2_o == 8'h57, "R6 column byte for 0x80", {16'h0, ecc2_o}, 24'h57);

        // R5: same block, exchanged order
        run_block(1'b1, 0, 1'b0, "R5 alt order");
        chk({ecc0_o, ecc1_o} == 16'h9966, "R5 line bytes swapped", {8'h0, ecc0_o, ecc1_o}, 24'h009966);

        // R4 / R5 on random data
        rand_blk();
        run_block(1'b0, 0, 1'b0, "R4 random normal");
        held = {ecc0_o, ecc1_o, ecc2_o};
        run_block(1'b1, 0, 1'b0, "R5 random alt");
        chk({ecc1_o, ecc0_o, ecc2_o} == held, "R5 swap vs normal", {ecc1_o, ecc0_o, ecc2_o}, held);

        // R9: gaps in the stream
        rand_blk();
        run_block(1'b0, 3, 1'b0, "R9 gapped stream");

        // R10: abort mid-block, junk byte in the start cycle
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 100; i++) begin
            valid_i = 1'b1; data_i = 8'($urandom);
            @(negedge clk);
        end
        rand_blk();
        run_block(1'b0, 0, 1'b1, "R10 restart mid-block");

        // R8 / R11: after done, unsolicited bytes change nothing
        held  = {ecc0_o, ecc1_o, ecc2_o};
        stray = 1'b0;
        for (int i = 0; i < 300; i++) begin
            valid_i = 1'b1; data_i = 8'($urandom);
            @(negedge clk);
            if (done_o) stray = 1'b1;
        end
        valid_i = 1'b0;
        chk(!stray, "R11 no done without start", {23'h0, stray}, 24'h0);
        chk({ecc0_o, ecc1_o, ecc2_o} == held, "R8 code holds until start", {ecc0_o, ecc1_o, ecc2_o}, held);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R8 every block produced done", 24'(exp_q.size()), 24'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule